// File: doc/BRIEF.md
# Accumulator Machine Fetch-Execute Sequencer

This block is the control unit and datapath of a multi-cycle machine built around a 64-bit accumulator. It reads one 64-bit instruction per step from a word-addressed memory. The instruction first passes through a buffer register into an instruction register. The block then executes it one register-transfer step per clock. The only arithmetic instruction is an add. Its first operand comes from one of 64 general registers and is loaded into the accumulator (AC). Its second operand is loaded into a data register (DR). The sum of the two is left in AC.

Two mode bits in the instruction choose, each on its own, how the two operands are obtained. The register operand is taken either straight from the register file or from memory at an address held in that register. The memory operand is taken either from memory at the instruction's address field or straight from that field as an immediate value. The four combinations produce four different step sequences. Both the number of memory reads and the length of each instruction depend on the mode. A stop opcode freezes the sequencer, and any unknown opcode also stops it and raises a flag. The register file comes out of reset holding its own index in every entry (R[i] = i), so indirect accesses have known targets with no write path.

Top module: `acc_seq_top`

## Requirements
- R1: While reset is held, `halted`, `illegal`, `retire` and `mem_rd` are 0 and `acc` is 0. The first memory read after reset is at address 0.
- R2: Each instruction is fetched with exactly one memory read at the program counter, and the counter then advances by one. Reads go out in this order: the fetch, then the indirect read if any, then the direct read if any. Two reads never happen in back-to-back cycles.
- R3: The instruction word is laid out as opcode [63:56] (add = 0x01, stop = 0xFF), mode [55:54], register number [53:48], ignored [47:32], and address/immediate [31:0].
- R4: When mode bit 55 is 0, AC is loaded with R[reg]. After reset, R[i] = i.
- R5: When mode bit 55 is 1, the block reads memory at the low 32 bits of R[reg] and loads AC with the returned word.
- R6: When mode bit 54 is 0, the block reads memory at instruction bits [31:0] and loads DR with the returned word.
- R7: When mode bit 54 is 1, DR is loaded with instruction bits [31:0] zero-extended to 64 bits, and no memory read is made for that operand.
- R8: After an add, `acc` holds (AC + DR) mod 2^64. `retire` is high for exactly one cycle, and `acc` already shows the sum in that cycle.
- R9: An add takes 8 cycles in mode 00, 7 in mode 01, 9 in mode 10 and 8 in mode 11, measured from one `retire` pulse to the next.
- R10: The stop opcode raises `halted` and holds it until reset. After that there are no further memory reads, `acc` is unchanged, and `illegal` stays 0.
- R11: Any opcode other than add or stop raises both `halted` and `illegal`.
- R12: `mem_wr` is never asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Word address, driven from the address register |
| mem_rdata | input | 64 | Read word, sampled at the clock edge that ends a cycle with `mem_rd` high |
| mem_wdata | output | 64 | Write data (carries AC) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| acc | output | 64 | Accumulator contents |
| retire | output | 1 | One-cycle pulse after each add completes |
| halted | output | 1 | Sequencer stopped |
| illegal | output | 1 | Stopped on an unknown opcode |

## Verification
A read is issued one cycle after its address is set up. The fetch read therefore falls in the second cycle of each instruction, and the operand reads follow the decode step. `retire` rises in the cycle after the add step, and the gap to the next `retire` is 7, 8 or 9 cycles, depending on the mode of the next instruction. The bench samples every output on the falling clock edge. Its monitor takes expected read addresses, sums and inter-retire gaps from queues in the order the driver queued them, so each result is checked in the exact cycle it is due. After a stop, any read that is not expected counts as a failure.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

   // Fixed opcode encodings (8-bit opcode field)
   localparam int unsigned    OPC_W   = 8;
   localparam logic [OPC_W-1:0] OPC_ADD  = 8'h01;
   localparam logic [OPC_W-1:0] OPC_STOP = 8'hFF;

   typedef enum logic [3:0] {
      ST_SETADR,   // MAR <- PC
      ST_FETCH,    // MBR <- M[MAR], PC <- PC + 1
      ST_LOADIR,   // IR <- MBR
      ST_DECODE,
      ST_REGOP,    // AC <- R[reg]  or  MAR <- R[reg]
      ST_INDRD,    // AC <- M[MAR]
      ST_OPADR,    // MAR <- IR.addr
      ST_OPRD,     // DR <- M[MAR]
      ST_OPIMM,    // DR <- zext(IR.addr)
      ST_SUM,      // AC <- AC + DR
      ST_STOP
   } seq_state_e;

   // One-hot-ish micro-operation strobes from control to datapath
   typedef struct packed {
      logic mar_from_pc;
      logic fetch_rd;
      logic ir_load;
      logic ac_from_reg;
      logic mar_from_reg;
      logic ac_from_mem;
      logic mar_from_ir;
      logic dr_from_mem;
      logic dr_from_imm;
      logic ac_from_sum;
   } uop_t;

endpackage

// File: rtl/acc_regfile.sv
module acc_regfile #(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned NREG       = 64,
   parameter bit          INIT_INDEX = 1'b1,
   localparam int unsigned RW        = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RW-1:0]   rd_sel,
   output logic [XLEN-1:0] rd_data
);

   if ((1 << RW) != NREG) begin : g_chk_pow2
      $error("acc_regfile: NREG must be a power of two");
   end

   logic [XLEN-1:0] words [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_word
      logic [XLEN-1:0] q;
      if (INIT_INDEX) begin : g_idx
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= XLEN'(i);
            else        q <= q;
         end
      end else begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= q;
         end
      end
      assign words[i] = q;
   end

   assign rd_data = words[rd_sel];

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
   import acc_seq_pkg::*;
#(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned AW        = 32,
   parameter int unsigned NREG      = 64,
   parameter logic [31:0] RESET_PC  = 32'h0,
   parameter bit          ADD_SPLIT = 1'b0,
   localparam int unsigned RW       = $clog2(NREG),
   localparam int unsigned MODE_LSB = XLEN - OPC_W - 2,
   localparam int unsigned REG_LSB  = MODE_LSB - RW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  uop_t             uop,
   input  logic [XLEN-1:0]  mem_rdata,
   input  logic [XLEN-1:0]  reg_rdata,
   output logic [AW-1:0]    mar_q,
   output logic [OPC_W-1:0] opcode,
   output logic [1:0]       mode,
   output logic [RW-1:0]    reg_sel,
   output logic [XLEN-1:0]  ac_q
);

   logic [AW-1:0]   pc_q;
   logic [XLEN-1:0] mbr_q, ir_q, dr_q, sum;

   assign opcode  = ir_q[XLEN-1 -: OPC_W];
   assign mode    = ir_q[MODE_LSB +: 2];
   assign reg_sel = ir_q[REG_LSB +: RW];

   logic unused_rsvd;
   assign unused_rsvd = ^ir_q[REG_LSB-1:AW];

   // Adder variant
   if (ADD_SPLIT) begin : g_add_split
      localparam int unsigned H = XLEN / 2;
      logic [H:0] lo;
      assign lo  = {1'b0, ac_q[H-1:0]} + {1'b0, dr_q[H-1:0]};
      assign sum = {ac_q[XLEN-1:H] + dr_q[XLEN-1:H] + {{(XLEN-H-1){1'b0}}, lo[H]},
                    lo[H-1:0]};
   end else begin : g_add_flat
      assign sum = ac_q + dr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC[AW-1:0];
         mar_q <= RESET_PC[AW-1:0];
         mbr_q <= '0;
         ir_q  <= '0;
         ac_q  <= '0;
         dr_q  <= '0;
      end else begin
         if (uop.mar_from_pc)  mar_q <= pc_q;
         if (uop.mar_from_reg) mar_q <= reg_rdata[AW-1:0];
         if (uop.mar_from_ir)  mar_q <= ir_q[AW-1:0];
         if (uop.fetch_rd) begin
            mbr_q <= mem_rdata;
            pc_q  <= pc_q + AW'(1);
         end
         if (uop.ir_load)      ir_q <= mbr_q;
         if (uop.ac_from_reg)  ac_q <= reg_rdata;
         if (uop.ac_from_mem)  ac_q <= mem_rdata;
         if (uop.ac_from_sum)  ac_q <= sum;
         if (uop.dr_from_mem)  dr_q <= mem_rdata;
         if (uop.dr_from_imm)  dr_q <= {{(XLEN-AW){1'b0}}, ir_q[AW-1:0]};
      end
   end

   // R2: the program counter moves only on a fetch read
   pc_fetch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !uop.fetch_rd |=> $stable(pc_q));

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   input  logic [1:0]       mode,
   output uop_t             uop,
   output logic             mem_rd,
   output logic             halted,
   output logic             illegal,
   output logic             retire
);

   seq_state_e state_q, state_d;
   logic       illegal_q, retire_q;

   always_comb begin
      uop     = '0;
      state_d = state_q;
      unique case (state_q)
         ST_SETADR: begin uop.mar_from_pc = 1'b1; state_d = ST_FETCH;  end
         ST_FETCH:  begin uop.fetch_rd    = 1'b1; state_d = ST_LOADIR; end
         ST_LOADIR: begin uop.ir_load     = 1'b1; state_d = ST_DECODE; end
         ST_DECODE: state_d = (opcode == OPC_ADD) ? ST_REGOP : ST_STOP;
         ST_REGOP: begin
            if (mode[1]) begin
               uop.mar_from_reg = 1'b1;
               state_d = ST_INDRD;
            end else begin
               uop.ac_from_reg = 1'b1;
               state_d = mode[0] ? ST_OPIMM : ST_OPADR;
            end
         end
         ST_INDRD: begin
            uop.ac_from_mem = 1'b1;
            state_d = mode[0] ? ST_OPIMM : ST_OPADR;
         end
         ST_OPADR: begin uop.mar_from_ir = 1'b1; state_d = ST_OPRD; end
         ST_OPRD:  begin uop.dr_from_mem = 1'b1; state_d = ST_SUM;  end
         ST_OPIMM: begin uop.dr_from_imm = 1'b1; state_d = ST_SUM;  end
         ST_SUM:   begin uop.ac_from_sum = 1'b1; state_d = ST_SETADR; end
         ST_STOP:  state_d = ST_STOP;
         default:  state_d = ST_STOP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_SETADR;
         illegal_q <= 1'b0;
         retire_q  <= 1'b0;
      end else begin
         state_q  <= state_d;
         retire_q <= (state_q == ST_SUM);
         if (state_q == ST_DECODE && opcode != OPC_ADD && opcode != OPC_STOP)
            illegal_q <= 1'b1;
      end
   end

   assign mem_rd  = uop.fetch_rd | uop.ac_from_mem | uop.dr_from_mem;
   assign halted  = (state_q == ST_STOP);
   assign illegal = illegal_q;
   assign retire  = retire_q;

   // R10
   stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && !mem_rd);
   // R11
   illegal_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> halted);
   // R2
   no_b2b_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);
   // R8
   retire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> !retire);

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
   import acc_seq_pkg::*;
#(
   parameter int unsigned XLEN          = 64,
   parameter int unsigned AW            = 32,
   parameter int unsigned NREG          = 64,
   parameter logic [31:0] RESET_PC      = 32'h0,
   parameter bit          ADD_SPLIT     = 1'b0,
   parameter bit          RF_INIT_INDEX = 1'b1,
   localparam int unsigned RW           = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [AW-1:0]   mem_addr,
   input  logic [XLEN-1:0] mem_rdata,
   output logic [XLEN-1:0] mem_wdata,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [XLEN-1:0] acc,
   output logic            retire,
   output logic            halted,
   output logic            illegal
);

   if (XLEN < OPC_W + 2 + RW + AW) begin : g_chk_fit
      $error("acc_seq_top: instruction fields do not fit in XLEN");
   end
   if (AW > 32) begin : g_chk_aw
      $error("acc_seq_top: AW above 32 not supported");
   end

   uop_t             uop;
   logic [OPC_W-1:0] opcode;
   logic [1:0]       mode;
   logic [RW-1:0]    reg_sel;
   logic [XLEN-1:0]  reg_rdata;

   acc_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .opcode  (opcode),
      .mode    (mode),
      .uop     (uop),
      .mem_rd  (mem_rd),
      .halted  (halted),
      .illegal (illegal),
      .retire  (retire)
   );

   acc_datapath #(
      .XLEN      (XLEN),
      .AW        (AW),
      .NREG      (NREG),
      .RESET_PC  (RESET_PC),
      .ADD_SPLIT (ADD_SPLIT)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .uop       (uop),
      .mem_rdata (mem_rdata),
      .reg_rdata (reg_rdata),
      .mar_q     (mem_addr),
      .opcode    (opcode),
      .mode      (mode),
      .reg_sel   (reg_sel),
      .ac_q      (acc)
   );

   acc_regfile #(
      .XLEN       (XLEN),
      .NREG       (NREG),
      .INIT_INDEX (RF_INIT_INDEX)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_sel  (reg_sel),
      .rd_data (reg_rdata)
   );

   assign mem_wdata = acc;
   assign mem_wr    = 1'b0;

endmodule

// File: tb/tb_acc_seq_top.sv
module tb_acc_seq_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr;
   logic [63:0] mem_rdata, mem_wdata, acc;
   logic        mem_rd, mem_wr, retire, halted, illegal;

   logic [63:0] mem [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mem_rdata = mem[mem_addr[5:0]];

   acc_seq_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .mem_wdata (mem_wdata),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .acc       (acc),
      .retire    (retire),
      .halted    (halted),
      .illegal   (illegal)
   );

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct { logic [31:0] addr; string tag; } rd_item_t;
   typedef struct { logic [63:0] sum; int gap; string tag; } ret_item_t;
   rd_item_t  rd_q[$];
   ret_item_t ret_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_add(input logic [1:0] m, input logic [5:0] r,
                                          input logic [31:0] a);
      return {8'h01, m, r, 16'h0000, a};
   endfunction

   task automatic exp_rd(input logic [31:0] a, input string tag);
      rd_item_t it;
      it.addr = a; it.tag = tag;
      rd_q.push_back(it);
   endtask

   task automatic exp_ret(input logic [63:0] s, input int gap, input string tag);
      ret_item_t it;
      it.sum = s; it.gap = gap; it.tag = tag;
      ret_q.push_back(it);
   endtask

   // Monitor: pops expectations as reads and retires happen
   int cyc = 0;
   int last_ret = -1;
   always @(negedge clk) begin
      if (!rst_n) begin
         cyc = 0;
         last_ret = -1;
      end else begin
         cyc++;
         if (mem_wr) check(1'b0, "R12", "write strobe", 64'(mem_wr), 64'd0);
         if (mem_rd) begin
            if (rd_q.size() == 0)
               check(1'b0, "R10/R11", "unexpected read", 64'(mem_addr), 64'd0);
            else begin
               rd_item_t e;
               e = rd_q.pop_front();
               check(mem_addr == e.addr, e.tag, "read address", 64'(mem_addr), 64'(e.addr));
            end
         end
         if (retire) begin
            if (ret_q.size() == 0)
               check(1'b0, "R8", "unexpected retire", acc, 64'd0);
            else begin
               ret_item_t e;
               e = ret_q.pop_front();
               check(acc == e.sum, e.tag, "accumulator", acc, e.sum);
               if (e.gap > 0)
                  check(cyc - last_ret == e.gap, "R9", "cycles per add",
                        64'(cyc - last_ret), 64'(e.gap));
            end
            last_ret = cyc;
         end
      end
   end

   task automatic reset_and_check();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset values
      check(halted == 1'b0 && illegal == 1'b0, "R1", "flags in reset",
            {62'd0, halted, illegal}, 64'd0);
      check(retire == 1'b0 && mem_rd == 1'b0, "R1", "strobes in reset",
            {62'd0, retire, mem_rd}, 64'd0);
      check(acc == 64'd0, "R1", "acc in reset", acc, 64'd0);
   endtask

   task automatic wait_halt();
      for (int i = 0; i < 300 && !halted; i++) @(negedge clk);
   endtask

   // Driver
   initial begin
      logic [63:0] s0, s1, s2, s3, s4, held;
      for (int i = 0; i < 64; i++) mem[i] = 64'd0;

      // Program A: all four modes, then stop
      mem[0] = mk_add(2'b00, 6'd5,  32'd40);
      mem[1] = mk_add(2'b01, 6'd63, 32'hFFFF_FFFF);
      mem[2] = mk_add(2'b10, 6'd41, 32'd42);
      mem[3] = mk_add(2'b11, 6'd43, 32'd7);
      mem[4] = mk_add(2'b10, 6'd44, 32'd45);
      mem[5] = {8'hFF, 56'd0};
      mem[40] = 64'h1234_5678_9ABC_DEF0;
      mem[41] = 64'h8000_0000_0000_0001;
      mem[42] = 64'h0000_0000_0000_0010;
      mem[43] = 64'd100;
      mem[44] = 64'hFFFF_FFFF_FFFF_FFFF;
      mem[45] = 64'd2;

      s0 = 64'd5 + mem[40];                 // R4 direct reg, R6 direct mem
      s1 = 64'd63 + 64'h0000_0000_FFFF_FFFF; // R7 zero extension
      s2 = mem[41] + mem[42];               // R5 indirect through R41
      s3 = mem[43] + 64'd7;                 // R5 + R7
      s4 = mem[44] + mem[45];               // R8 wraps to 1

      exp_rd(32'd0, "R1");  exp_rd(32'd40, "R6");
      exp_ret(s0, 0, "R4");
      exp_rd(32'd1, "R2");
      exp_ret(s1, 7, "R7");
      exp_rd(32'd2, "R2");  exp_rd(32'd41, "R5"); exp_rd(32'd42, "R6");
      exp_ret(s2, 9, "R5");
      exp_rd(32'd3, "R2");  exp_rd(32'd43, "R5");
      exp_ret(s3, 8, "R7");
      exp_rd(32'd4, "R3");  exp_rd(32'd44, "R5"); exp_rd(32'd45, "R6");
      exp_ret(s4, 9, "R8");
      exp_rd(32'd5, "R10");

      reset_and_check();
      rst_n = 1'b1;
      wait_halt();
      check(halted == 1'b1, "R10", "stopped", 64'(halted), 64'd1);
      check(illegal == 1'b0, "R10", "no illegal on stop", 64'(illegal), 64'd0);
      held = acc;
      check(acc == s4, "R10", "acc at stop", acc, s4);
      repeat (20) @(negedge clk);
      check(acc == held && halted == 1'b1, "R10", "acc frozen after stop", acc, held);
      check(rd_q.size() == 0 && ret_q.size() == 0, "R2", "all expected events seen",
            64'(rd_q.size() + ret_q.size()), 64'd0);

      // Program B: one add, then an unknown opcode
      for (int i = 0; i < 64; i++) mem[i] = 64'd0;
      mem[0] = mk_add(2'b01, 6'd1, 32'd2);
      mem[1] = {8'h37, 56'd0};
      exp_rd(32'd0, "R1");
      exp_ret(64'd3, 0, "R4");
      exp_rd(32'd1, "R11");

      reset_and_check();
      rst_n = 1'b1;
      wait_halt();
      repeat (2) @(negedge clk);
      check(halted == 1'b1 && illegal == 1'b1, "R11", "unknown opcode stops",
            {62'd0, halted, illegal}, 64'd3);
      check(acc == 64'd3, "R11", "acc kept", acc, 64'd3);
      repeat (10) @(negedge clk);
      check(rd_q.size() == 0 && ret_q.size() == 0, "R11", "all expected events seen",
            64'(rd_q.size() + ret_q.size()), 64'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule